// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic heart of a dot-product kernel such as an FIR filter tap loop. Each clock it can take a pair of signed 16-bit fractional operands (1.15 format) and multiply them. It then either loads the product into a 40-bit accumulator or adds the product to it. The accumulator carries 8 guard bits above the 32-bit product width, so long sums can pass the ±1.0 range for a while without losing information.

A kernel typically runs as follows. One load step clears the accumulator and takes the first product in the same cycle. Accumulate steps follow for the middle terms. The last term goes through a rounding accumulate, which rounds the sum to the upper part of the word. A final saturate step then clamps the sum only if it has left the 32-bit range.

The 16-bit result word is always bits 31..16 of the accumulator. The overflow flag is always the guard-bit check on the current accumulator.

Top module: `fxp_mac`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first accepted command, `acc_o` is 0, `ovf_o` is 0 and `res_o` is 0.
- R2: With `in_valid_i` low, the accumulator keeps its value whatever `cmd_i`, `a_i` and `b_i` carry.
- R3: Command 2'b00 (load) discards the old accumulator and loads the fractional product: signed `a_i`×`b_i`, shifted left one bit and sign-extended to 40 bits.
- R4: Command 2'b01 (accumulate) adds the fractional product to the accumulator, modulo 2^40.
- R5: The product of -1.0 by -1.0 (0x8000 × 0x8000) enters the accumulator as +1.0, which is 40'h00_8000_0000. It is never negated by wrap.
- R6: Command 2'b10 (round accumulate) forms accumulator + product + 2^15 and then clears bits 15..0. A remainder of exactly 0x8000 therefore rounds up.
- R7: `ovf_o` is 1 exactly when accumulator bits 39..31 are not all equal.
- R8: Command 2'b11 (saturate) with `ovf_o` high replaces the accumulator with 40'h00_7FFF_FFFF if bit 39 is 0, or with 40'hFF_8000_0000 if bit 39 is 1. After this, `ovf_o` is low.
- R9: Command 2'b11 with `ovf_o` low leaves the accumulator unchanged, and the operands are ignored.
- R10: `res_o` always equals accumulator bits 31..16.
- R11: An accepted command updates `acc_o` after the next rising edge. Commands may issue on every consecutive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Command and operands valid this cycle |
| cmd_i | input | 2 | 00 load, 01 accumulate, 10 round accumulate, 11 saturate |
| a_i | input | 16 | Signed 1.15 operand (data) |
| b_i | input | 16 | Signed 1.15 operand (coefficient) |
| acc_o | output | 40 | Accumulator contents |
| ovf_o | output | 1 | Sum outside the 32-bit range |
| res_o | output | 16 | Result word, accumulator bits 31..16 |

## Verification
The bench targets four corner cases.

- Squaring -1.0: a multiplier that shifts inside 32 bits turns +1.0 into -1.0.
- A rounding tie at exactly half an LSB: a design that uses the wrong round bit, or that rounds half down, leaves the result word one low.
- Saturation of sums that have gone beyond +1.0 and beyond -1.0: a wrong sign decode clamps to the opposite rail.
- A saturate command on a sum that is still in range: a design that saturates unconditionally corrupts a good result.

Random back-to-back command streams also check guard-bit wrap and the overflow flag on every cycle.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
   typedef enum logic [1:0] {
      CMD_LOAD = 2'b00,
      CMD_ACC  = 2'b01,
      CMD_RND  = 2'b10,
      CMD_SAT  = 2'b11
   } mac_cmd_e;
endpackage

// File: rtl/fxp_mac_mult.sv
// Signed multiplier, sign-extended to the accumulator width.
// FRAC selects fractional (1.15 x 1.15, shifted left one) or integer alignment.
module fxp_mac_mult #(
   parameter int DW   = 16,
   parameter int AW   = 40,
   parameter bit FRAC = 1'b1
) (
   input  logic signed [DW-1:0] a_i,
   input  logic signed [DW-1:0] b_i,
   output logic        [AW-1:0] prod_o
);
   localparam int PW    = 2 * DW;
   localparam int GUARD = AW - PW;

   logic signed [PW-1:0] raw;
   logic        [AW-1:0] ext;

   assign raw = a_i * b_i;
   assign ext = {{GUARD{raw[PW-1]}}, raw};

   generate
      if (FRAC) begin : g_frac
         // shift happens at full width so +1.0 keeps its sign
         assign prod_o = {ext[AW-2:0], 1'b0};
      end else begin : g_int
         assign prod_o = ext;
      end
   endgenerate
endmodule

// File: rtl/fxp_mac_adder.sv
// Accumulator adder with optional round-half-up on the result word boundary.
module fxp_mac_adder #(
   parameter int AW = 40,
   parameter int RB = 16
) (
   input  logic [AW-1:0] acc_i,
   input  logic [AW-1:0] prod_i,
   input  logic          base_zero_i,
   input  logic          round_i,
   output logic [AW-1:0] sum_o
);
   localparam logic [AW-1:0] HALF = AW'(1) << (RB - 1);
   localparam logic [AW-1:0] KEEP = ~((AW'(1) << RB) - AW'(1));

   logic [AW-1:0] base;
   logic [AW-1:0] plain;
   logic [AW-1:0] biased;

   assign base   = base_zero_i ? '0 : acc_i;
   assign plain  = base + prod_i;
   assign biased = plain + HALF;

   always_comb begin
      if (round_i) sum_o = biased & KEEP;
      else         sum_o = plain;
   end
endmodule

// File: rtl/fxp_mac_sat.sv
// Guard-bit overflow detect and the clamp value chosen by the sign bit.
module fxp_mac_sat #(
   parameter int AW = 40,
   parameter int PW = 32
) (
   input  logic [AW-1:0] acc_i,
   output logic          ovf_o,
   output logic [AW-1:0] clamp_o
);
   localparam int TOP = AW - PW + 1;

   logic [TOP-1:0] hi;

   assign hi      = acc_i[AW-1:PW-1];
   assign ovf_o   = !((&hi) || !(|hi));
   assign clamp_o = acc_i[AW-1] ? {{TOP{1'b1}}, {(PW-1){1'b0}}}
                                : {{TOP{1'b0}}, {(PW-1){1'b1}}};
endmodule

// File: rtl/fxp_mac.sv
module fxp_mac #(
   parameter int DW    = 16,
   parameter int GUARD = 8,
   parameter bit FRAC  = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          in_valid_i,
   input  logic [1:0]    cmd_i,
   input  logic [15:0]   a_i,
   input  logic [15:0]   b_i,
   output logic [39:0]   acc_o,
   output logic          ovf_o,
   output logic [15:0]   res_o
);
   import fxp_mac_pkg::*;

   localparam int PW = 2 * DW;
   localparam int AW = PW + GUARD;

   generate
      if (DW != 16 || GUARD != 8) begin : g_bad_width
         $error("fxp_mac: port widths assume DW=16 and GUARD=8");
      end
   endgenerate

   mac_cmd_e      cmd;
   logic [AW-1:0] acc_q, acc_d;
   logic [AW-1:0] prod, sum, clamp;
   logic          ovf;

   assign cmd = mac_cmd_e'(cmd_i);

   fxp_mac_mult #(.DW(DW), .AW(AW), .FRAC(FRAC)) u_mult (
      .a_i    (a_i),
      .b_i    (b_i),
      .prod_o (prod)
   );

   fxp_mac_adder #(.AW(AW), .RB(DW)) u_add (
      .acc_i       (acc_q),
      .prod_i      (prod),
      .base_zero_i (cmd == CMD_LOAD),
      .round_i     (cmd == CMD_RND),
      .sum_o       (sum)
   );

   fxp_mac_sat #(.AW(AW), .PW(PW)) u_sat (
      .acc_i   (acc_q),
      .ovf_o   (ovf),
      .clamp_o (clamp)
   );

   always_comb begin
      acc_d = acc_q;
      if (in_valid_i) begin
         unique case (cmd)
            CMD_SAT: if (ovf) acc_d = clamp;
            default: acc_d = sum;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q <= '0;
      else         acc_q <= acc_d;
   end

   assign acc_o = acc_q;
   assign ovf_o = ovf;
   assign res_o = acc_q[PW-1:DW];
endmodule

// File: rtl/fxp_mac_chk.sv
module fxp_mac_chk #(
   parameter int DW    = 16,
   parameter int GUARD = 8
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          in_valid_i,
   input logic [1:0]    cmd_i,
   input logic [39:0]   acc_o,
   input logic          ovf_o,
   input logic [15:0]   res_o
);
   // R2
   hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(acc_o));

   // R6
   round_clears_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && cmd_i == 2'b10) |=> (acc_o[15:0] == 16'h0));

   // R8
   sat_clears_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && cmd_i == 2'b11 && ovf_o) |=>
         (!ovf_o && (acc_o == 40'h00_7FFF_FFFF || acc_o == 40'hFF_8000_0000)));

   // R8
   sat_keeps_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && cmd_i == 2'b11 && ovf_o) |=> (acc_o[39] == $past(acc_o[39])));

   // R9
   sat_inrange_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && cmd_i == 2'b11 && !ovf_o) |=> $stable(acc_o));
endmodule

bind fxp_mac fxp_mac_chk #(.DW(DW), .GUARD(GUARD)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .in_valid_i (in_valid_i),
   .cmd_i      (cmd_i),
   .acc_o      (acc_o),
   .ovf_o      (ovf_o),
   .res_o      (res_o)
);

// File: tb/fxp_mac_bench.sv
`timescale 1ns/1ps
module fxp_mac_bench;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        in_valid_i = 1'b0;
   logic [1:0]  cmd_i = 2'b00;
   logic [15:0] a_i = '0, b_i = '0;
   logic [39:0] acc_o;
   logic        ovf_o;
   logic [15:0] res_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [39:0] exp_acc = '0;

   always #2.5 clk_i = ~clk_i;

   fxp_mac u_fxp_mac (
      .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .cmd_i(cmd_i),
      .a_i(a_i), .b_i(b_i), .acc_o(acc_o), .ovf_o(ovf_o), .res_o(res_o)
   );

   function automatic logic [39:0] frac_prod(logic [15:0] a, logic [15:0] b);
      logic signed [31:0] p;
      logic [39:0] e;
      p = $signed(a) * $signed(b);
      e = {{8{p[31]}}, p};
      return e << 1;
   endfunction

   function automatic logic exp_ovf(logic [39:0] v);
      return !((&v[39:31]) || !(|v[39:31]));
   endfunction

   function automatic logic [39:0] model(logic [39:0] acc, logic [1:0] c,
                                         logic [15:0] a, logic [15:0] b);
      logic [39:0] t;
      case (c)
         2'b00: return frac_prod(a, b);
         2'b01: return acc + frac_prod(a, b);
         2'b10: begin
            t = acc + frac_prod(a, b) + 40'h8000;
            t[15:0] = '0;
            return t;
         end
         default: begin
            if (!exp_ovf(acc)) return acc;
            return acc[39] ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
         end
      endcase
   endfunction

   task automatic check(string tag);
      n_chk++;
      if (acc_o !== exp_acc || ovf_o !== exp_ovf(exp_acc) || res_o !== exp_acc[31:16]) begin
         n_fail++;
         $display("FAIL %s: acc=%h ovf=%b res=%h expected acc=%h ovf=%b res=%h", tag,
                  acc_o, ovf_o, res_o, exp_acc, exp_ovf(exp_acc), exp_acc[31:16]);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, compare at the next falling edge (R11)
   task automatic do_op(logic v, logic [1:0] c, logic [15:0] a, logic [15:0] b, string tag);
      in_valid_i = v; cmd_i = c; a_i = a; b_i = b;
      @(negedge clk_i);
      if (v) exp_acc = model(exp_acc, c, a, b);
      check(tag);
   endtask

   function automatic logic [15:0] rnd_opnd();
      case ($urandom_range(0, 5))
         0: return 16'h8000;
         1: return 16'h7FFF;
         2: return 16'hFFFF;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'h5EED_2024));
      repeat (3) @(negedge clk_i);
      check("R1 in reset");
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1 after release");

      do_op(1, 2'b00, 16'h4000, 16'h4000, "R3 load 0.25");
      do_op(0, 2'b00, 16'h1234, 16'h5678, "R2 idle load ignored");
      do_op(0, 2'b11, 16'hFFFF, 16'hFFFF, "R2 idle sat ignored");
      do_op(1, 2'b01, 16'h8000, 16'h8000, "R5 R7 -1 squared overflows");
      do_op(1, 2'b11, 16'hAAAA, 16'h5555, "R8 R10 positive clamp 7FFF");
      do_op(1, 2'b11, 16'h8000, 16'h8000, "R9 sat in range no change");
      do_op(1, 2'b00, 16'h8000, 16'h8000, "R5 load -1 squared");
      do_op(1, 2'b00, 16'h0001, 16'h4000, "R3 load half lsb");
      do_op(1, 2'b10, 16'h0000, 16'h1234, "R6 tie rounds up");
      do_op(1, 2'b00, 16'h8000, 16'h7FFF, "R3 load negative");
      do_op(1, 2'b01, 16'h8000, 16'h7FFF, "R4 R7 negative overflow");
      do_op(1, 2'b11, 16'h0000, 16'h0000, "R8 negative clamp 8000");
      do_op(1, 2'b10, 16'hFFFF, 16'h0001, "R6 round negative");
      for (int i = 0; i < 300; i++)
         do_op(1, 2'b01, 16'h7FFF, 16'h7FFF, "R4 guard-bit fill and wrap");

      for (int i = 0; i < 4000; i++) begin
         logic [1:0] c;
         logic v;
         v = ($urandom_range(0, 9) != 0);
         c = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b01;
         do_op(v, c, rnd_opnd(), rnd_opnd(),
               !v ? "R2 random idle" : c == 2'b00 ? "R3 R11 random load" :
               c == 2'b01 ? "R4 R7 R11 random acc" :
               c == 2'b10 ? "R6 R11 random round" : "R8 R9 random sat");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule